// File: doc/BRIEF.md
# Read-only instruction cache controller

This block controls a small set-associative level-1 instruction cache whose lines are either invalid or valid (read-only). A core presents line-aligned fetch requests; a fetch that finds its line valid is answered on the next cycle with the line address and the full line of data. A fetch that misses is consumed at once and, after a fixed issue delay, produces a single read-block request toward one of several level-2 banks. The bank number comes from a configurable slice of address bits that begins directly above the line-offset bits. No line is reserved at miss time.

When data comes back on the response port, the controller writes it into the way that already holds the line or into the lowest free way of its set, marks the line valid, forwards the data to the core and pops the response. If the set is full, the controller first invalidates the way named by that set's round-robin pointer, advances the pointer and leaves the response waiting; the fill is taken on the next cycle. Only one miss is outstanding at a time: further misses wait, hits continue. A fetch of an unknown kind and a response of an unknown kind are both consumed and flagged on a one-cycle error output.

Top module: `icache_ctl`

## Requirements
- R1: After reset every line is invalid, fr_valid, dq_valid and proto_err are low, and the first fetch of any address misses.
- R2: A fetch (fq_kind 2'd0) to a valid line is accepted in the cycle it is presented (fr_ready high) and fr_valid shows that address and the stored line on the next cycle; no downstream request follows.
- R3: A fetch (fq_kind 2'd0) to an invalid line is consumed, produces no core response, and dq_valid rises exactly ISSUE_LAT cycles after the accepting edge with dq_addr equal to the fetch address and dq_src equal to REQ_ID; dq_valid and dq_addr hold until dq_ready.
- R4: dq_bank equals dq_addr[OFF_BITS +: BANK_BITS].
- R5: A data response (dr_kind 2'd1) whose line is present or whose set has a free way is accepted in the cycle it is presented, writes the line, and is returned on fr_valid/fr_addr/fr_data on the next cycle; later hits to that line return the new data.
- R6: A data response whose set is full and which misses is not accepted in its first cycle; one way is invalidated and the response is accepted one cycle later, so the core sees it two cycles after it was presented.
- R7: The evicted way of a set starts at way 0 after reset and advances by one, wrapping, on each eviction in that set; other ways keep their lines.
- R8: While a miss is outstanding (from its acceptance until its fill is accepted), a fetch that misses is held with fq_ready low; a fetch that hits is still served.
- R9: A fetch whose kind is not 2'd0 is accepted at once, yields no response and no request, and proto_err[0] is high for exactly the next cycle.
- R10: A response whose kind is not 2'd1 is popped at once without changing any line, and proto_err[1] is high for exactly the next cycle.
- R11: While dr_valid is high, fq_ready is low: responses are handled before fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fq_valid | input | 1 | Fetch request valid |
| fq_ready | output | 1 | Fetch request accepted |
| fq_kind | input | 2 | Request kind, 2'd0 = instruction fetch |
| fq_addr | input | ADDR_W | Line-aligned fetch address |
| fr_valid | output | 1 | Core response valid |
| fr_ready | input | 1 | Core takes the response |
| fr_addr | output | ADDR_W | Address of the returned line |
| fr_data | output | DATA_W | Returned line data |
| dq_valid | output | 1 | Downstream read-block request valid |
| dq_ready | input | 1 | Downstream takes the request |
| dq_addr | output | ADDR_W | Requested line address |
| dq_bank | output | BANK_BITS | Target level-2 bank |
| dq_src | output | REQ_ID_W | Requester identity |
| dr_valid | input | 1 | Downstream response valid |
| dr_ready | output | 1 | Response popped |
| dr_kind | input | 2 | Response kind, 2'd1 = data |
| dr_addr | input | ADDR_W | Line address of the response |
| dr_data | input | DATA_W | Line data of the response |
| proto_err | output | 2 | One-cycle pulses: [0] bad fetch kind, [1] bad response kind |

## Verification
Fetches are tried as cold misses, as repeat hits, as misses issued while another miss is open and as hits slipped in under an open miss, which separates the hit path from the miss serialisation. Fills are sent into sets with a free way, into a set whose line is already present and into a full set three times in a row, so the retry cycle and the wrap of the round-robin pointer are told apart from a plain write. Fetches and responses of unknown kind, and a response presented together with a fetch, separate the error pulses and the response-first ordering from the normal flow. Request timing and bank bits are compared against the configured issue delay and address slice for lines in two different sets.

// File: rtl/icc_pkg.sv
package icc_pkg;

    localparam logic [1:0] KIND_FETCH = 2'd0;
    localparam logic [1:0] RSP_DATA   = 2'd1;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_WAIT,
        MS_SEND,
        MS_FILL
    } miss_phase_e;

endpackage

// File: rtl/icc_line_store.sv
module icc_line_store #(
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              rd_set_a,
    output logic [WAYS-1:0]               a_valid,
    output logic [WAYS-1:0][TAG_W-1:0]    a_tag,
    output logic [WAYS-1:0][DATA_W-1:0]   a_data,
    input  logic [IDX_W-1:0]              rd_set_b,
    output logic [WAYS-1:0]               b_valid,
    output logic [WAYS-1:0][TAG_W-1:0]    b_tag,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_set,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          inv_en,
    input  logic [IDX_W-1:0]              inv_set,
    input  logic [WAY_W-1:0]              inv_way
);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]              valid;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag;
        logic [SETS-1:0][WAYS-1:0][DATA_W-1:0]  data;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (inv_en) begin
            st_d.valid[inv_set][inv_way] = 1'b0;
        end
        if (wr_en) begin
            st_d.valid[wr_set][wr_way] = 1'b1;
            st_d.tag[wr_set][wr_way]   = wr_tag;
            st_d.data[wr_set][wr_way]  = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_valid = st_q.valid[rd_set_a];
    assign a_tag   = st_q.tag[rd_set_a];
    assign a_data  = st_q.data[rd_set_a];
    assign b_valid = st_q.valid[rd_set_b];
    assign b_tag   = st_q.tag[rd_set_b];

endmodule

// File: rtl/icc_way_match.sv
module icc_way_match #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 8,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  tag,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way
);

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (valid[w] && (tag[w] == key) && !hit) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/icc_victim_rr.sv
module icc_victim_rr #(
    parameter int SETS = 4,
    parameter int WAYS = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_set,
    output logic [WAY_W-1:0]  victim,
    input  logic              adv_en,
    input  logic [IDX_W-1:0]  adv_set
);

    typedef struct packed {
        logic [SETS-1:0][WAY_W-1:0] ptr;
    } rr_t;

    rr_t rr_d, rr_q;

    always_comb begin
        rr_d = rr_q;
        if (adv_en) begin
            if (rr_q.ptr[adv_set] == WAY_W'(WAYS - 1)) begin
                rr_d.ptr[adv_set] = '0;
            end else begin
                rr_d.ptr[adv_set] = rr_q.ptr[adv_set] + WAY_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else begin
            rr_q <= rr_d;
        end
    end

    assign victim = rr_q.ptr[rd_set];

endmodule

// File: rtl/icc_miss_slot.sv
module icc_miss_slot
    import icc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int OFF_BITS  = 6,
    parameter int ISSUE_LAT = 80,
    localparam int CNT_W    = $clog2(ISSUE_LAT + 1),
    localparam int LINE_W   = ADDR_W - OFF_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic               dq_ready,
    input  logic               fill_pop,
    input  logic [LINE_W-1:0]  fill_line,
    output logic               busy,
    output logic               dq_valid,
    output logic [ADDR_W-1:0]  dq_addr
);

    typedef struct packed {
        miss_phase_e        phase;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  addr;
    } slot_t;

    slot_t sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        unique case (sl_q.phase)
            MS_IDLE: begin
                if (start) begin
                    sl_d.addr  = start_addr;
                    sl_d.cnt   = CNT_W'(ISSUE_LAT - 1);
                    sl_d.phase = MS_WAIT;
                end
            end
            MS_WAIT: begin
                if (sl_q.cnt == '0) begin
                    sl_d.phase = MS_SEND;
                end else begin
                    sl_d.cnt = sl_q.cnt - CNT_W'(1);
                end
            end
            MS_SEND: begin
                if (dq_ready) begin
                    sl_d.phase = MS_FILL;
                end
            end
            MS_FILL: begin
                if (fill_pop && (fill_line == sl_q.addr[ADDR_W-1:OFF_BITS])) begin
                    sl_d.phase = MS_IDLE;
                end
            end
            default: sl_d.phase = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sl_q <= '{phase: MS_IDLE, cnt: '0, addr: '0};
        end else begin
            sl_q <= sl_d;
        end
    end

    assign busy     = (sl_q.phase != MS_IDLE);
    assign dq_valid = (sl_q.phase == MS_SEND);
    assign dq_addr  = sl_q.addr;

endmodule

// File: rtl/icache_ctl.sv
module icache_ctl
    import icc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int OFF_BITS  = 6,
    parameter int SETS      = 4,
    parameter int WAYS      = 2,
    parameter int DATA_W    = 64,
    parameter int BANK_BITS = 2,
    parameter int ISSUE_LAT = 80,
    parameter int REQ_ID_W  = 4,
    parameter logic [REQ_ID_W-1:0] REQ_ID = 4'd5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fq_valid,
    output logic                  fq_ready,
    input  logic [1:0]            fq_kind,
    input  logic [ADDR_W-1:0]     fq_addr,
    output logic                  fr_valid,
    input  logic                  fr_ready,
    output logic [ADDR_W-1:0]     fr_addr,
    output logic [DATA_W-1:0]     fr_data,
    output logic                  dq_valid,
    input  logic                  dq_ready,
    output logic [ADDR_W-1:0]     dq_addr,
    output logic [BANK_BITS-1:0]  dq_bank,
    output logic [REQ_ID_W-1:0]   dq_src,
    input  logic                  dr_valid,
    output logic                  dr_ready,
    input  logic [1:0]            dr_kind,
    input  logic [ADDR_W-1:0]     dr_addr,
    input  logic [DATA_W-1:0]     dr_data,
    output logic [1:0]            proto_err
);

    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - OFF_BITS - IDX_W;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int LINE_W = ADDR_W - OFF_BITS;

    typedef struct packed {
        logic               fr_valid;
        logic [ADDR_W-1:0]  fr_addr;
        logic [DATA_W-1:0]  fr_data;
        logic [1:0]         err;
    } top_t;

    top_t t_d, t_q;

    // address split
    logic [IDX_W-1:0] f_set, r_set;
    logic [TAG_W-1:0] f_tag, r_tag;
    assign f_set = fq_addr[OFF_BITS +: IDX_W];
    assign f_tag = fq_addr[ADDR_W-1 -: TAG_W];
    assign r_set = dr_addr[OFF_BITS +: IDX_W];
    assign r_tag = dr_addr[ADDR_W-1 -: TAG_W];

    // line store views
    logic [WAYS-1:0]              a_valid, b_valid;
    logic [WAYS-1:0][TAG_W-1:0]   a_tag, b_tag;
    logic [WAYS-1:0][DATA_W-1:0]  a_data;

    logic             wr_en, inv_en, rr_adv, miss_start, miss_busy, fill_pop;
    logic [WAY_W-1:0] wr_way, victim;
    logic             f_hit, r_hit, r_free;
    logic [WAY_W-1:0] f_hit_way, r_hit_way, r_free_way;
    logic             out_free;

    icc_line_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_set_a(f_set), .a_valid(a_valid), .a_tag(a_tag), .a_data(a_data),
        .rd_set_b(r_set), .b_valid(b_valid), .b_tag(b_tag),
        .wr_en(wr_en), .wr_set(r_set), .wr_way(wr_way), .wr_tag(r_tag), .wr_data(dr_data),
        .inv_en(inv_en), .inv_set(r_set), .inv_way(victim)
    );

    icc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_f (
        .valid(a_valid), .tag(a_tag), .key(f_tag), .hit(f_hit), .hit_way(f_hit_way)
    );

    icc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match_r (
        .valid(b_valid), .tag(b_tag), .key(r_tag), .hit(r_hit), .hit_way(r_hit_way)
    );

    icc_victim_rr #(.SETS(SETS), .WAYS(WAYS)) u_rr (
        .clk(clk), .rst_n(rst_n), .rd_set(r_set), .victim(victim),
        .adv_en(rr_adv), .adv_set(r_set)
    );

    icc_miss_slot #(
        .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .ISSUE_LAT(ISSUE_LAT)
    ) u_miss (
        .clk(clk), .rst_n(rst_n), .start(miss_start), .start_addr(fq_addr),
        .dq_ready(dq_ready), .fill_pop(fill_pop), .fill_line(dr_addr[ADDR_W-1:OFF_BITS]),
        .busy(miss_busy), .dq_valid(dq_valid), .dq_addr(dq_addr)
    );

    // lowest free way of the response set
    always_comb begin
        r_free     = 1'b0;
        r_free_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!b_valid[w] && !r_free) begin
                r_free     = 1'b1;
                r_free_way = WAY_W'(w);
            end
        end
    end

    assign wr_way   = r_hit ? r_hit_way : r_free_way;
    assign out_free = !t_q.fr_valid || fr_ready;
    assign fill_pop = dr_valid && dr_ready && (dr_kind == RSP_DATA);

    always_comb begin
        t_d        = t_q;
        t_d.err    = '0;
        fq_ready   = 1'b0;
        dr_ready   = 1'b0;
        wr_en      = 1'b0;
        inv_en     = 1'b0;
        rr_adv     = 1'b0;
        miss_start = 1'b0;
        if (fr_ready) begin
            t_d.fr_valid = 1'b0;
        end
        if (dr_valid) begin
            if (dr_kind != RSP_DATA) begin
                dr_ready   = 1'b1;
                t_d.err[1] = 1'b1;
            end else if (r_hit || r_free) begin
                if (out_free) begin
                    dr_ready     = 1'b1;
                    wr_en        = 1'b1;
                    t_d.fr_valid = 1'b1;
                    t_d.fr_addr  = dr_addr;
                    t_d.fr_data  = dr_data;
                end
            end else begin
                // full set: drop one way now, take the fill next cycle
                inv_en = 1'b1;
                rr_adv = 1'b1;
            end
        end else if (fq_valid) begin
            if (fq_kind != KIND_FETCH) begin
                fq_ready   = 1'b1;
                t_d.err[0] = 1'b1;
            end else if (f_hit) begin
                if (out_free) begin
                    fq_ready     = 1'b1;
                    t_d.fr_valid = 1'b1;
                    t_d.fr_addr  = fq_addr;
                    t_d.fr_data  = a_data[f_hit_way];
                end
            end else if (!miss_busy) begin
                fq_ready   = 1'b1;
                miss_start = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign fr_valid  = t_q.fr_valid;
    assign fr_addr   = t_q.fr_addr;
    assign fr_data   = t_q.fr_data;
    assign proto_err = t_q.err;
    assign dq_bank   = dq_addr[OFF_BITS +: BANK_BITS];
    assign dq_src    = REQ_ID;

endmodule

// File: rtl/icc_checker.sv
module icc_checker
    import icc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int OFF_BITS  = 6,
    parameter int BANK_BITS = 2,
    parameter int DATA_W    = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fq_valid,
    input logic                  fq_ready,
    input logic [1:0]            fq_kind,
    input logic                  fr_valid,
    input logic                  fr_ready,
    input logic [ADDR_W-1:0]     fr_addr,
    input logic [DATA_W-1:0]     fr_data,
    input logic                  dq_valid,
    input logic                  dq_ready,
    input logic [ADDR_W-1:0]     dq_addr,
    input logic [BANK_BITS-1:0]  dq_bank,
    input logic                  dr_valid,
    input logic                  dr_ready,
    input logic [1:0]            dr_kind,
    input logic [1:0]            proto_err
);

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && !dq_ready) |=> (dq_valid && $stable(dq_addr)));

    assert_bank_slice_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_valid |-> (dq_bank == dq_addr[OFF_BITS +: BANK_BITS]));

    assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && !fr_ready) |=> (fr_valid && $stable(fr_addr) && $stable(fr_data)));

    assert_bad_fetch_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fq_valid && fq_ready && (fq_kind != KIND_FETCH)) |=> proto_err[0]);

    assert_bad_rsp_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_valid && dr_ready && (dr_kind != RSP_DATA)) |=> proto_err[1]);

    assert_rsp_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dr_valid |-> !fq_ready);

endmodule

bind icache_ctl icc_checker #(
    .ADDR_W(ADDR_W), .OFF_BITS(OFF_BITS), .BANK_BITS(BANK_BITS), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_kind(fq_kind),
    .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_addr(fr_addr), .fr_data(fr_data),
    .dq_valid(dq_valid), .dq_ready(dq_ready), .dq_addr(dq_addr), .dq_bank(dq_bank),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_kind(dr_kind),
    .proto_err(proto_err)
);

// File: tb/sim_icache_ctl.sv
`timescale 1ns/1ps
module sim_icache_ctl;

    localparam int LAT = 20;
    localparam logic [3:0] SRC = 4'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        fq_valid = 1'b0, fq_ready;
    logic [1:0]  fq_kind = 2'd0;
    logic [15:0] fq_addr = '0;
    logic        fr_valid, fr_ready = 1'b1;
    logic [15:0] fr_addr;
    logic [63:0] fr_data;
    logic        dq_valid, dq_ready = 1'b1;
    logic [15:0] dq_addr;
    logic [1:0]  dq_bank;
    logic [3:0]  dq_src;
    logic        dr_valid = 1'b0, dr_ready;
    logic [1:0]  dr_kind = 2'd1;
    logic [15:0] dr_addr = '0;
    logic [63:0] dr_data = '0;
    logic [1:0]  proto_err;

    icache_ctl #(.ISSUE_LAT(LAT), .REQ_ID(SRC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .fq_valid(fq_valid), .fq_ready(fq_ready), .fq_kind(fq_kind), .fq_addr(fq_addr),
        .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_addr(fr_addr), .fr_data(fr_data),
        .dq_valid(dq_valid), .dq_ready(dq_ready), .dq_addr(dq_addr), .dq_bank(dq_bank),
        .dq_src(dq_src),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_kind(dr_kind), .dr_addr(dr_addr),
        .dr_data(dr_data), .proto_err(proto_err)
    );

    typedef struct { logic [15:0] a; logic [63:0] d; int c; } fexp_t;
    typedef struct { logic [15:0] a; logic [1:0] b; int c; } dexp_t;

    fexp_t frq[$];
    dexp_t dqq[$];
    logic [63:0] mdl [logic [15:0]];
    int cyc = 0, checks = 0, fails = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] mk(logic [15:0] a, int s);
        return {a ^ 16'hA5A5, a + 16'(s), ~a, 16'(s * 7 + 3)};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // monitor: core responses (R2, R5, R6)
    fexp_t fe;
    dexp_t de;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (fr_valid) begin
                if (frq.size() == 0) begin
                    chk(1'b0, "R2/R9", "unexpected core response addr", 64'(fr_addr), 64'h0);
                end else begin
                    fe = frq.pop_front();
                    chk(fr_addr == fe.a, "R2/R5", "response addr", 64'(fr_addr), 64'(fe.a));
                    chk(fr_data == fe.d, "R2/R5", "response data", fr_data, fe.d);
                    chk(cyc == fe.c, "R2/R5/R6", "response cycle", 64'(cyc), 64'(fe.c));
                end
            end
            if (dq_valid) begin
                if (dqq.size() == 0) begin
                    chk(1'b0, "R3/R9", "unexpected downstream request", 64'(dq_addr), 64'h0);
                end else begin
                    de = dqq.pop_front();
                    chk(dq_addr == de.a, "R3", "request addr", 64'(dq_addr), 64'(de.a));
                    chk(dq_bank == de.b, "R4", "request bank", 64'(dq_bank), 64'(de.b));
                    chk(dq_src == SRC, "R3", "request source", 64'(dq_src), 64'(SRC));
                    chk(cyc == de.c, "R3", "request cycle", 64'(cyc), 64'(de.c));
                end
            end
        end
    end

    // mode: 0 hit, 1 miss, 2 bad kind
    task automatic fetch(logic [15:0] a, logic [1:0] k, int mode, string req);
        int waited = 0;
        int c;
        @(negedge clk);
        fq_valid = 1'b1; fq_kind = k; fq_addr = a;
        #1;
        while (!fq_ready && waited < 400) begin
            @(negedge clk); #1; waited++;
        end
        c = cyc;
        if (mode != 1) chk(waited == 0, req, "accept delay", 64'(waited), 64'h0);
        else chk(waited < 400, req, "miss accepted", 64'(waited), 64'h0);
        if (mode == 0) frq.push_back('{a, mdl[a], c + 1});
        if (mode == 1) dqq.push_back('{a, a[7:6], c + 1 + LAT});
        @(negedge clk);
        fq_valid = 1'b0;
        if (mode == 2) begin
            chk(proto_err == 2'b01, req, "bad fetch flag", 64'(proto_err), 64'h1);
            @(negedge clk);
            chk(proto_err == 2'b00, req, "bad fetch flag clears", 64'(proto_err), 64'h0);
        end
    endtask

    task automatic fill(logic [15:0] a, logic [1:0] k, int seed, bit evict, string req);
        int waited = 0;
        int c0, c;
        logic [63:0] d;
        d = mk(a, seed);
        @(negedge clk);
        dr_valid = 1'b1; dr_kind = k; dr_addr = a; dr_data = d;
        #1;
        c0 = cyc;
        if (evict) chk(dr_ready == 1'b0, "R6", "full set holds fill first cycle", 64'(dr_ready), 64'h0);
        while (!dr_ready && waited < 50) begin
            @(negedge clk); #1; waited++;
        end
        c = cyc;
        if (evict) chk(c == c0 + 1, "R6", "fill accept after eviction", 64'(c), 64'(c0 + 1));
        else chk(c == c0, req, "fill accept cycle", 64'(c), 64'(c0));
        if (k == 2'd1) begin
            mdl[a] = d;
            frq.push_back('{a, d, c + 1});
        end
        @(negedge clk);
        dr_valid = 1'b0;
        if (k != 2'd1) begin
            chk(proto_err == 2'b10, "R10", "bad response flag", 64'(proto_err), 64'h2);
            @(negedge clk);
            chk(proto_err == 2'b00, "R10", "bad response flag clears", 64'(proto_err), 64'h0);
        end
    endtask

    task automatic wait_dq();
        int n = 0;
        while (dqq.size() != 0 && n < 500) begin
            @(negedge clk); n++;
        end
        @(negedge clk);
    endtask

    // stall probe for R8: a missing fetch must not be accepted
    task automatic probe_stall(logic [15:0] a);
        @(negedge clk);
        fq_valid = 1'b1; fq_kind = 2'd0; fq_addr = a;
        #1;
        chk(fq_ready == 1'b0, "R8", "second miss held", 64'(fq_ready), 64'h0);
        fq_valid = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not finish", 64'(cyc), 64'h0);
        summary();
    end

    localparam logic [15:0] LA = 16'h0140;
    localparam logic [15:0] LB = 16'h0240;
    localparam logic [15:0] LC = 16'h0340;
    localparam logic [15:0] LE = 16'h02C0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(fr_valid == 1'b0, "R1", "fr_valid after reset", 64'(fr_valid), 64'h0);
        chk(dq_valid == 1'b0, "R1", "dq_valid after reset", 64'(dq_valid), 64'h0);
        chk(proto_err == 2'b00, "R1", "proto_err after reset", 64'(proto_err), 64'h0);

        // R1/R3/R4: cold miss, R8: further miss held
        fetch(LA, 2'd0, 1, "R1");
        probe_stall(LB);
        wait_dq();
        fill(LA, 2'd1, 0, 1'b0, "R5");
        fetch(LA, 2'd0, 0, "R2");

        // second way of set 1, then another set (bank 3)
        fetch(LB, 2'd0, 1, "R3");
        wait_dq();
        fill(LB, 2'd1, 0, 1'b0, "R5");
        fetch(LE, 2'd0, 1, "R4");
        wait_dq();
        fill(LE, 2'd1, 0, 1'b0, "R5");

        // R8: hit under an open miss; R6/R7 eviction of way 0 (LA)
        fetch(LC, 2'd0, 1, "R3");
        fetch(LA, 2'd0, 0, "R8");
        probe_stall(16'h0580);
        wait_dq();
        fill(LC, 2'd1, 0, 1'b1, "R6");
        fetch(LB, 2'd0, 0, "R7");
        fetch(LA, 2'd0, 1, "R7");
        wait_dq();
        fill(LA, 2'd1, 1, 1'b1, "R7");
        fetch(LC, 2'd0, 0, "R7");
        fetch(LB, 2'd0, 1, "R7");
        wait_dq();
        fill(LB, 2'd1, 2, 1'b1, "R7");
        fetch(LA, 2'd0, 0, "R5");
        fetch(LB, 2'd0, 0, "R5");

        // R9: bad fetch kind
        fetch(LA, 2'd2, 2, "R9");
        fetch(LC, 2'd3, 2, "R9");

        // R10: bad response kind leaves LE untouched
        fill(LE, 2'd0, 9, 1'b0, "R10");
        fetch(LE, 2'd0, 0, "R10");

        // R11: response presented together with a fetch
        @(negedge clk);
        dr_valid = 1'b1; dr_kind = 2'd3; dr_addr = LE; dr_data = '1;
        fq_valid = 1'b1; fq_kind = 2'd0; fq_addr = LE;
        #1;
        chk(fq_ready == 1'b0, "R11", "fetch held while response valid", 64'(fq_ready), 64'h0);
        chk(dr_ready == 1'b1, "R11", "response taken first", 64'(dr_ready), 64'h1);
        @(negedge clk);
        dr_valid = 1'b0;
        chk(proto_err == 2'b10, "R11", "response error flag", 64'(proto_err), 64'h2);
        #1;
        chk(fq_ready == 1'b1, "R11", "fetch taken after response", 64'(fq_ready), 64'h1);
        frq.push_back('{LE, mdl[LE], cyc + 1});
        @(negedge clk);
        fq_valid = 1'b0;

        // R5: fill to a present line overwrites it
        fill(LE, 2'd1, 3, 1'b0, "R5");
        fetch(LE, 2'd0, 0, "R5");

        repeat (5) @(negedge clk);
        chk(frq.size() == 0, "R2/R5", "pending core responses", 64'(frq.size()), 64'h0);
        chk(dqq.size() == 0, "R3", "pending downstream requests", 64'(dqq.size()), 64'h0);
        summary();
    end

endmodule